// File: doc/BRIEF.md
# Multi-channel PS/2 interrupt generator

This block drives the interrupt lines of a PS/2 port controller with several channels (three by default). It works in one of two modes, selected by the `shift_en` input. While the shift engine is running, two sticky flags record that a transaction has started or ended. The shift engine signals these events with single-cycle detect pulses. Each flag reaches interrupt line 0 only when its own enable bit is set.

While the shift engine is disabled, the flags are ignored. Each channel's PS/2 clock input is brought into the system clock domain by a plain two-flop synchronizer, with no debounce, and drives that channel's interrupt line. Firmware can then run the PS/2 protocol by taking an interrupt on each clock edge. A single gate enable turns this routing on or off for all channels.

The three enable bits sit in one configuration register. The register is written through a simple address/data/write-strobe bus. Reading it returns the enables together with the two flag states. The block has no data stream: all of its pins are plain control and status lines, so there is no valid/ready handshake and no back-pressure.

Top module: `ps2_irq_gen`

## Requirements
- R1: With `shift_en`=1, irq[0] is 1 whenever the start flag is set and enable bit 0 is 1. With enable bit 0 at 0, the start flag has no effect on irq[0].
- R2: With `shift_en`=1, irq[0] is 1 whenever the end flag is set and enable bit 1 is 1. With enable bit 1 at 0, the end flag has no effect on irq[0].
- R3: A detect pulse sets its flag at the next clock edge. The flag then stays set until a `shift_rst` strobe, whatever the detect inputs do. Clearing the enable bit removes the interrupt while the flag stays set.
- R4: When `shift_rst` and a detect pulse arrive in the same cycle, the flag is 0 after the edge.
- R5: With `shift_en`=0 and enable bit 2 at 1, irq[i] equals the value that ch_clk[i] had two rising clock edges earlier, for every channel i.
- R6: When enable bit 2 is 0, or when `shift_en`=1, irq[i] for i≥1 is 0 and the channel clocks have no effect on any interrupt line.
- R7: irq[0] is the OR of the start term, the end term and the channel-0 clock term. With `shift_en`=0, the flags and enable bits 0 and 1 have no effect on irq[0].
- R8: A write with `cfg_we`=1 to address 0 loads enable bits [2:0] from cfg_wdata[2:0] at the next edge. Reading address 0 returns {0…, end flag at bit 4, start flag at bit 3, enables at bits [2:0]}. Writes to any other address are ignored, and reads of any other address return 0. After reset, the enables and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | 1 = shift engine active (flag mode), 0 = clock-routing mode |
| shift_rst | input | 1 | Shift engine reset strobe; clears both flags |
| sot_det | input | 1 | Start-of-transaction detect pulse |
| eot_det | input | 1 | End-of-transaction detect pulse |
| ch_clk | input | NUM_CH | Asynchronous PS/2 clock inputs, one per channel |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | DATA_W | Configuration read data (combinational on cfg_addr) |
| irq | output | NUM_CH | Interrupt lines, one per channel |

## Verification
The bench goes after a detect pulse that arrives together with a shift reset. A design that let the set win would leave a flag stuck high and show a spurious interrupt after the reset. It checks that flags outlive their pulses and that clearing an enable silences irq[0] while the readback still shows the flag set. A design that cleared flags on read or on disable would fail that check. It switches modes while the flags are set, to catch a design that let flags leak onto irq[0] in routing mode or let clocks leak in shift mode. It also counts the two-edge synchronizer latency exactly, so a missing or extra stage shows up as a shifted copy of the clock pattern.

// File: rtl/ps2_irq_pkg.sv
package ps2_irq_pkg;
  // Enable/status bit positions in the configuration register
  localparam int unsigned BIT_EN_SOT = 0;
  localparam int unsigned BIT_EN_EOT = 1;
  localparam int unsigned BIT_EN_CLK = 2;
  localparam int unsigned BIT_ST_SOT = 3;
  localparam int unsigned BIT_ST_EOT = 4;
  localparam int unsigned NUM_EN     = 3;
  localparam int unsigned NUM_FLAGS  = 2;
  localparam int unsigned FLAG_SOT   = 0;
  localparam int unsigned FLAG_EOT   = 1;

  typedef struct packed {
    logic clk_irq;
    logic eot;
    logic sot;
  } irq_en_t;
endpackage

// File: rtl/ps2_irq_sync.sv
module ps2_irq_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ps2_irq_flags.sv
module ps2_irq_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);
  for (genvar f = 0; f < N; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[f] <= 1'b0;
      else if (clr)    flag[f] <= 1'b0;   // reset strobe has priority
      else if (set[f]) flag[f] <= 1'b1;
    end
  end
endmodule

// File: rtl/ps2_irq_cfg.sv
module ps2_irq_cfg
  import ps2_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CFG_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 we,
  input  logic [NUM_FLAGS-1:0] flags,
  output irq_en_t              en,
  output logic [DATA_W-1:0]    rdata
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);

  logic hit;
  logic unused_wdata;
  assign hit          = (addr == MY_ADDR);
  assign unused_wdata = ^wdata[DATA_W-1:NUM_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en <= '0;
    else if (we && hit) en <= irq_en_t'(wdata[NUM_EN-1:0]);
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[NUM_EN-1:0] = en;
      rdata[BIT_ST_SOT] = flags[FLAG_SOT];
      rdata[BIT_ST_EOT] = flags[FLAG_EOT];
    end
  end
endmodule

// File: rtl/ps2_irq_gen.sv
module ps2_irq_gen
  import ps2_irq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_rst,
  input  logic              sot_det,
  input  logic              eot_det,
  input  logic [NUM_CH-1:0] ch_clk,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_CH-1:0]    clk_sync;
  irq_en_t              en_q;
  logic                 proto_term;
  logic                 route_on;

  ps2_irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ch_clk), .sync_out(clk_sync)
  );

  ps2_irq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(shift_rst),
    .set({eot_det, sot_det}), .flag(flag_q)
  );

  ps2_irq_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(0)) u_cfg (
    .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .wdata(cfg_wdata),
    .we(cfg_we), .flags(flag_q), .en(en_q), .rdata(cfg_rdata)
  );

  // Protocol events only count while the shift engine runs
  assign proto_term = shift_en &
                      ((flag_q[FLAG_SOT] & en_q.sot) | (flag_q[FLAG_EOT] & en_q.eot));
  // Raw clock routing only while the shift engine is off
  assign route_on = ~shift_en & en_q.clk_irq;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    if (c == 0) begin : g_primary
      assign irq[c] = proto_term | (route_on & clk_sync[c]);
    end else begin : g_secondary
      assign irq[c] = route_on & clk_sync[c];
    end
  end
endmodule

// File: rtl/ps2_irq_chk.sv
module ps2_irq_chk #(
  parameter int unsigned NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              shift_rst,
  input logic [NUM_CH-1:0] ch_clk,
  input logic [NUM_CH-1:0] irq,
  input logic [1:0]        flag_q,
  input logic [2:0]        en_q
);
  logic [1:0]        seen;
  logic [NUM_CH-1:0] clk_d1, clk_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0; clk_d1 <= '0; clk_d2 <= '0;
    end else begin
      if (seen != 2'd3) seen <= seen + 2'd1;
      clk_d1 <= ch_clk;
      clk_d2 <= clk_d1;
    end
  end

  p_sot_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && flag_q[0] && en_q[0]) |-> irq[0]);
  p_eot_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && flag_q[1] && en_q[1]) |-> irq[0]);
  p_sot_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !shift_rst) |=> flag_q[0]);
  p_eot_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !shift_rst) |=> flag_q[1]);
  p_rst_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rst |=> (flag_q == 2'b00));
  p_clk_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2 && !shift_en && en_q[2]) |-> (irq == clk_d2));
  p_clk_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en || !en_q[2]) |-> (irq[NUM_CH-1:1] == '0));
  p_shift_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !en_q[2]) |-> !irq[0]);
endmodule

bind ps2_irq_gen ps2_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_rst(shift_rst),
  .ch_clk(ch_clk), .irq(irq), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/sim_ps2_irq_gen.sv
`timescale 1ns/1ps
module sim_ps2_irq_gen;
  localparam int NCH = 3;
  localparam int AW  = 2;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b1, shift_rst = 1'b0, sot_det = 1'b0, eot_det = 1'b0;
  logic [NCH-1:0] ch_clk = '0;
  logic [AW-1:0]  cfg_addr = '0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic           cfg_we = 1'b0;
  logic [DW-1:0]  cfg_rdata;
  logic [NCH-1:0] irq;

  always #2.5 clk = ~clk;

  ps2_irq_gen #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_rst(shift_rst),
    .sot_det(sot_det), .eot_det(eot_det), .ch_clk(ch_clk),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model state
  logic [2:0]     m_en;
  logic           m_sot, m_eot;
  logic [NCH-1:0] m_s1, m_s2;

  function automatic logic [NCH-1:0] exp_irq();
    logic [NCH-1:0] r = '0;
    if (shift_en) r[0] = (m_sot & m_en[0]) | (m_eot & m_en[1]);
    else if (m_en[2]) r = m_s2;
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    logic [DW-1:0] r = '0;
    if (cfg_addr == '0) r[4:0] = {m_eot, m_sot, m_en};
    return r;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_en = '0; m_sot = 1'b0; m_eot = 1'b0; m_s1 = '0; m_s2 = '0;
    end else begin
      m_s2 = m_s1; m_s1 = ch_clk;
      if (shift_rst) begin m_sot = 1'b0; m_eot = 1'b0; end
      else begin
        if (sot_det) m_sot = 1'b1;
        if (eot_det) m_eot = 1'b1;
      end
      if (cfg_we && cfg_addr == '0) m_en = cfg_wdata[2:0];
    end
  endtask

  task automatic compare(string tag);
    n_cmp++;
    if (irq !== exp_irq()) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq());
    end
    n_cmp++;
    if (cfg_rdata !== exp_rdata()) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, cfg_rdata, exp_rdata());
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_in();
    shift_rst = 1'b0; sot_det = 1'b0; eot_det = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    step(tag);
    cfg_we = 1'b0; cfg_addr = '0;
  endtask

  initial begin
    model_edge();
    repeat (3) @(negedge clk);
    compare("R8 reset");
    rst_n = 1'b1;
    step("R8 post-reset");

    // R8: register access
    wr(2'd0, 8'hFD, "R8 write addr0");
    step("R8 readback");
    wr(2'd1, 8'h00, "R8 write other addr ignored");
    cfg_addr = 2'd1; step("R8 read other addr zero");
    cfg_addr = 2'd0; step("R8 enables kept");
    wr(2'd0, 8'h03, "R8 write flag enables");

    // R1: start flag gating
    shift_en = 1'b1; sot_det = 1'b1; step("R1 sot pulse");
    sot_det = 1'b0; step("R1 sot irq");
    // R3: sticky, disable removes irq
    repeat (3) step("R3 sot sticky");
    wr(2'd0, 8'h02, "R3 disable sot enable");
    step("R3 flag kept irq low");
    // R2: end flag gating
    eot_det = 1'b1; step("R2 eot pulse");
    eot_det = 1'b0; step("R2 eot irq");
    wr(2'd0, 8'h01, "R2 mask eot");
    step("R2 masked");
    // R4: reset wins
    shift_rst = 1'b1; sot_det = 1'b1; eot_det = 1'b1;
    step("R4 rst with set");
    idle_in(); step("R4 flags clear");
    wr(2'd0, 8'h07, "R4 all enables");
    step("R4 no irq after reset");

    // R7: flags set, routing mode, flags ignored
    sot_det = 1'b1; eot_det = 1'b1; step("R7 set flags");
    idle_in(); step("R7 flags irq");
    shift_en = 1'b0; ch_clk = '0; step("R7 flags ignored");
    step("R7 flags ignored 2");
    // R5: clock routing latency
    ch_clk = 3'b101; step("R5 edge1");
    ch_clk = 3'b010; step("R5 edge2");
    ch_clk = 3'b111; step("R5 edge3");
    ch_clk = 3'b000; step("R5 edge4");
    step("R5 edge5");
    // R6: gate disabled
    wr(2'd0, 8'h03, "R6 clock gate off");
    ch_clk = 3'b111; repeat (3) step("R6 clocks quiet");
    shift_en = 1'b1; wr(2'd0, 8'h04, "R6 shift mode");
    repeat (3) step("R6 shift mode quiet");

    // Random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      shift_en  = r[0] | r[1];
      shift_rst = (r[6:2] == 5'd0);
      sot_det   = (r[9:7] == 3'd0);
      eot_det   = (r[12:10] == 3'd0);
      ch_clk    = r[15:13];
      cfg_we    = (r[19:16] == 4'd0);
      cfg_addr  = (r[21:20] == 2'd3) ? 2'd1 : 2'd0;
      cfg_wdata = r[29:22];
      step("R7 random");
    end
    idle_in();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule